// File: doc/BRIEF.md
# SCSI Selection Command Sequencer

This block sits behind the command register of a SCSI initiator. It receives command bytes and decodes the selection-related operations. For each one it updates three registers: the bus phase, the interrupt cause and the sequence step. It also drives an interrupt request line. The operations are the three selection variants, initiator command complete, message accept, FIFO flush and bus reset. The block does not drive the SCSI bus and does not run the command block itself. At the point of selection it samples a per-target presence map and the occupancy of the command-byte FIFO, and from these it decides which outcome to report.

Commands are handled strictly one at a time. A byte written while another command is still in progress waits in a small holding queue and runs as soon as the current command finishes. Software clears the interrupt cause, the interrupt line and the error flag by pulsing the acknowledge input, which has the same effect as reading the interrupt register.

Top module: `sel_cmd_sequencer`

## Requirements
- R1: After reset, the phase, interrupt cause, sequence step, interrupt line, block-offset flag, DMA flag, error flag and all pulse outputs are 0, and busy is low.
- R2: Bits 6:0 of the command byte select the operation: 0x00 no-op, 0x01 flush, 0x03 bus reset, 0x11 initiator command complete, 0x12 message accept, 0x41 select, 0x42 select with attention, 0x43 select with attention and stop. Bit 7 marks a DMA command and is copied to `dma_cmd_o` when any recognised command runs.
- R3: If a selection command finds the addressed target absent (`tgt_present[dest_id]` low), the phase becomes 0, the interrupt cause is replaced by exactly 0x20 (disconnect), the sequence step becomes 0 and the interrupt line goes high.
- R4: Select (0x41) with the target present and a non-zero command-FIFO count sets phase 2 (command) and sequence step 4. It ORs 0x18 (bus service and function complete) into the interrupt cause, raises the interrupt, clears the block-offset flag and pulses `cmd_launch_o` for one cycle.
- R5: Select with attention (0x42) under the same conditions behaves as R4, except that the block-offset flag is set to 1 because the first byte is a message.
- R6: Select with attention and stop (0x43), with the target present and bytes available, sets phase 6 (message out) and sequence step 1. It ORs in 0x18, raises the interrupt, sets the block-offset flag and does not pulse `cmd_launch_o`.
- R7: A selection with the target present and a command-FIFO count of 0 sets phase 2 and step 4 (for 0x41 or 0x42), or phase 6 and step 1 (for 0x43). It adds no interrupt cause and does not touch the interrupt line.
- R8: Initiator command complete ORs 0x08 into the interrupt cause, sets phase 7 (message in) and raises the interrupt.
- R9: Message accept ORs 0x20 into the interrupt cause, clears the sequence step, pulses `fifo_flags_clr_o` for one cycle and raises the interrupt.
- R10: Flush pulses `fifo_flush_o` for one cycle and changes no register. A no-op changes nothing.
- R11: Bus reset ORs 0x80 into the interrupt cause and raises the interrupt when `rst_report_dis` is low. When it is high, the command changes nothing.
- R12: An unrecognised opcode leaves phase, cause, step, interrupt line and DMA flag unchanged, and sets `illegal_o`.
- R13: A command's results appear on the second rising edge after the edge that samples its write. A command written while another is queued or executing is held and runs in order, two edges after the previous result.
- R14: An `intr_ack` pulse clears the interrupt cause, the interrupt line and `illegal_o` on the next edge. The interrupt line is high exactly when the cause is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_wr | input | 1 | Command register write strobe |
| cmd_byte | input | 8 | Command byte: opcode in bits 6:0, DMA flag in bit 7 |
| dest_id | input | TID_W (3) | Destination target number, low bits of the bus-ID register |
| tgt_present | input | NUM_TARGETS (8) | One bit per target, high if a device answers |
| cmdq_count | input | CQ_CNT_W (5) | Bytes currently held in the command FIFO |
| rst_report_dis | input | 1 | Configuration bit that suppresses the bus-reset interrupt |
| intr_ack | input | 1 | Clears interrupt cause, interrupt line and error flag |
| phase_o | output | 3 | Bus phase field of the status register |
| intr_o | output | 8 | Interrupt cause register |
| seq_o | output | 3 | Sequence step register |
| irq_o | output | 1 | Interrupt request |
| cdb_off_o | output | 1 | High when the first command-FIFO byte is a message |
| dma_cmd_o | output | 1 | DMA flag of the last recognised command |
| illegal_o | output | 1 | Unrecognised command seen since last acknowledge |
| fifo_flush_o | output | 1 | One-cycle request to empty the data FIFO |
| fifo_flags_clr_o | output | 1 | One-cycle request to clear the FIFO flags |
| cmd_launch_o | output | 1 | One-cycle hand-off of the command block for execution |
| busy_o | output | 1 | A command is queued or executing |

## Verification
Each command's register values and pulses become valid on the second rising edge after the edge that captures the write. A command queued behind another completes two edges after the previous one. An acknowledge takes effect on the very next edge. The bench drives the interface on falling edges and stamps each expected item with the cycle in which it falls due, taking the later of the write time plus three and the previous due cycle plus two. The monitor compares all outputs, pulses included, on the falling edge of exactly that cycle. A pulse that arrives one cycle early or late therefore shows up as a miscompare.

// File: rtl/sel_seq_pkg.sv
// Shared encodings for the selection command sequencer.
// Assumes phase, cause and step codes are decoded by software as listed.
package sel_seq_pkg;

    // Phase field values
    localparam logic [2:0] PH_DOUT = 3'd0;
    localparam logic [2:0] PH_CMD  = 3'd2;
    localparam logic [2:0] PH_MOUT = 3'd6;
    localparam logic [2:0] PH_MIN  = 3'd7;

    // Interrupt cause bits
    localparam logic [7:0] IRQ_RST   = 8'h80;
    localparam logic [7:0] IRQ_DISC  = 8'h20;
    localparam logic [7:0] IRQ_BSVC  = 8'h10;
    localparam logic [7:0] IRQ_FDONE = 8'h08;

    // Sequence step values
    localparam logic [2:0] SEQ_IDLE = 3'd0;
    localparam logic [2:0] SEQ_MSG  = 3'd1;
    localparam logic [2:0] SEQ_CMD  = 3'd4;

    // Opcodes (bits 6:0 of the command byte)
    localparam logic [6:0] OPC_NOP     = 7'h00;
    localparam logic [6:0] OPC_FLUSH   = 7'h01;
    localparam logic [6:0] OPC_BUSRST  = 7'h03;
    localparam logic [6:0] OPC_ICCS    = 7'h11;
    localparam logic [6:0] OPC_MSGACC  = 7'h12;
    localparam logic [6:0] OPC_SEL     = 7'h41;
    localparam logic [6:0] OPC_SELATN  = 7'h42;
    localparam logic [6:0] OPC_SELSTOP = 7'h43;

    typedef enum logic [3:0] {
        OP_NOP, OP_FLUSH, OP_BUSRST, OP_ICCS, OP_MSGACC,
        OP_SEL, OP_SELATN, OP_SELSTOP, OP_BAD
    } op_e;

    // Register update produced by one executed command
    typedef struct packed {
        logic       ph_we;
        logic [2:0] ph;
        logic       ir_replace;
        logic [7:0] ir_bits;
        logic       sq_we;
        logic [2:0] sq;
        logic       cdb_we;
        logic       cdb;
        logic       raise;
        logic       launch;
        logic       flush;
        logic       fclr;
        logic       bad;
        logic       dma_we;
    } upd_t;

endpackage

// File: rtl/sel_cmd_fifo.sv
// Holding queue for command bytes written while the sequencer is busy.
// Assumes a push when full is dropped; pop is only requested when not empty.
module sel_cmd_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
    localparam logic [CW-1:0] FULLCNT = CW'(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] cnt;
    logic          push_ok, pop_ok;

    assign push_ok = push && (cnt != FULLCNT);
    assign pop_ok  = pop && (cnt != '0);
    assign empty   = (cnt == '0);
    assign dout    = mem[rd_ptr];

    // Store an accepted byte at the write pointer
    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= din;
    end

    // Advance pointers and occupancy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (push_ok) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + PW'(1);
            if (pop_ok)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + PW'(1);
            case ({push_ok, pop_ok})
                2'b10:   cnt <= cnt + CW'(1);
                2'b01:   cnt <= cnt - CW'(1);
                default: cnt <= cnt;
            endcase
        end
    end
endmodule

// File: rtl/sel_cmd_decode.sv
// Maps a command byte to an operation and its DMA flag.
// Assumes the opcode occupies bits 6:0 and bit 7 is the DMA marker.
module sel_cmd_decode
    import sel_seq_pkg::*;
(
    input  logic [7:0] cmd_byte,
    output op_e        op,
    output logic       dma
);
    assign dma = cmd_byte[7];

    // Translate the opcode field
    always_comb begin
        case (cmd_byte[6:0])
            OPC_NOP:     op = OP_NOP;
            OPC_FLUSH:   op = OP_FLUSH;
            OPC_BUSRST:  op = OP_BUSRST;
            OPC_ICCS:    op = OP_ICCS;
            OPC_MSGACC:  op = OP_MSGACC;
            OPC_SEL:     op = OP_SEL;
            OPC_SELATN:  op = OP_SELATN;
            OPC_SELSTOP: op = OP_SELSTOP;
            default:     op = OP_BAD;
        endcase
    end
endmodule

// File: rtl/sel_outcome.sv
// Computes the register update for one operation from the selection inputs.
// Assumes hit and has_bytes are sampled in the execute cycle.
module sel_outcome
    import sel_seq_pkg::*;
(
    input  op_e  op,
    input  logic hit,
    input  logic has_bytes,
    input  logic rr_dis,
    output upd_t upd
);
    logic stop;
    assign stop = (op == OP_SELSTOP);

    // Build the fixed outcome for each operation
    always_comb begin
        upd        = '0;
        upd.dma_we = 1'b1;
        case (op)
            OP_NOP: upd.dma_we = 1'b1;
            OP_FLUSH: upd.flush = 1'b1;
            OP_BUSRST: begin
                if (!rr_dis) begin
                    upd.ir_bits = IRQ_RST;
                    upd.raise   = 1'b1;
                end
            end
            OP_ICCS: begin
                upd.ph_we   = 1'b1;
                upd.ph      = PH_MIN;
                upd.ir_bits = IRQ_FDONE;
                upd.raise   = 1'b1;
            end
            OP_MSGACC: begin
                upd.ir_bits = IRQ_DISC;
                upd.sq_we   = 1'b1;
                upd.sq      = SEQ_IDLE;
                upd.fclr    = 1'b1;
                upd.raise   = 1'b1;
            end
            OP_SEL, OP_SELATN, OP_SELSTOP: begin
                if (!hit) begin
                    upd.ph_we      = 1'b1;
                    upd.ph         = PH_DOUT;
                    upd.ir_replace = 1'b1;
                    upd.ir_bits    = IRQ_DISC;
                    upd.sq_we      = 1'b1;
                    upd.sq         = SEQ_IDLE;
                    upd.raise      = 1'b1;
                end else begin
                    upd.ph_we = 1'b1;
                    upd.ph    = stop ? PH_MOUT : PH_CMD;
                    upd.sq_we = 1'b1;
                    upd.sq    = stop ? SEQ_MSG : SEQ_CMD;
                    if (has_bytes) begin
                        upd.ir_bits = IRQ_BSVC | IRQ_FDONE;
                        upd.raise   = 1'b1;
                        upd.cdb_we  = 1'b1;
                        upd.cdb     = (op != OP_SEL);
                        upd.launch  = !stop;
                    end
                end
            end
            default: begin
                upd.bad    = 1'b1;
                upd.dma_we = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/sel_cmd_sequencer.sv
// Top of the selection command sequencer: queues command bytes, runs one
// command every two cycles and holds the phase, cause and step registers.
// Assumes target map and FIFO count are stable in the execute cycle.
module sel_cmd_sequencer
    import sel_seq_pkg::*;
#(
    parameter int NUM_TARGETS = 8,
    parameter int CQ_CNT_W    = 5,
    parameter int HOLD_DEPTH  = 2,
    localparam int TID_W      = $clog2(NUM_TARGETS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cmd_wr,
    input  logic [7:0]             cmd_byte,
    input  logic [TID_W-1:0]       dest_id,
    input  logic [NUM_TARGETS-1:0] tgt_present,
    input  logic [CQ_CNT_W-1:0]    cmdq_count,
    input  logic                   rst_report_dis,
    input  logic                   intr_ack,
    output logic [2:0]             phase_o,
    output logic [7:0]             intr_o,
    output logic [2:0]             seq_o,
    output logic                   irq_o,
    output logic                   cdb_off_o,
    output logic                   dma_cmd_o,
    output logic                   illegal_o,
    output logic                   fifo_flush_o,
    output logic                   fifo_flags_clr_o,
    output logic                   cmd_launch_o,
    output logic                   busy_o
);
    typedef enum logic {ST_IDLE, ST_EVAL} st_e;

    st_e        state;
    logic [7:0] cur_cmd;
    logic [7:0] q_dout;
    logic       q_empty, q_pop, apply;
    op_e        op;
    logic       op_dma;
    upd_t       upd;
    logic [7:0] ir_base;

    assign q_pop  = (state == ST_IDLE) && !q_empty;
    assign apply  = (state == ST_EVAL);
    assign busy_o = !q_empty || (state != ST_IDLE);

    sel_cmd_fifo #(.W(8), .DEPTH(HOLD_DEPTH)) i_hold (
        .clk(clk), .rst_n(rst_n), .push(cmd_wr), .din(cmd_byte),
        .pop(q_pop), .dout(q_dout), .empty(q_empty)
    );

    sel_cmd_decode i_dec (.cmd_byte(cur_cmd), .op(op), .dma(op_dma));

    sel_outcome i_out (
        .op(op), .hit(tgt_present[dest_id]), .has_bytes(|cmdq_count),
        .rr_dis(rst_report_dis), .upd(upd)
    );

    assign ir_base = intr_ack ? 8'h00 : intr_o;

    // Fetch one command, then execute it on the following edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cur_cmd <= 8'h00;
        end else if (q_pop) begin
            state   <= ST_EVAL;
            cur_cmd <= q_dout;
        end else if (apply) begin
            state   <= ST_IDLE;
        end
    end

    // Register file updates, acknowledge first and execution on top
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_o   <= 3'd0;
            intr_o    <= 8'h00;
            seq_o     <= 3'd0;
            irq_o     <= 1'b0;
            cdb_off_o <= 1'b0;
            dma_cmd_o <= 1'b0;
            illegal_o <= 1'b0;
        end else begin
            intr_o    <= ir_base;
            irq_o     <= intr_ack ? 1'b0 : irq_o;
            illegal_o <= intr_ack ? 1'b0 : illegal_o;
            if (apply) begin
                intr_o <= (upd.ir_replace ? 8'h00 : ir_base) | upd.ir_bits;
                if (upd.raise)  irq_o     <= 1'b1;
                if (upd.bad)    illegal_o <= 1'b1;
                if (upd.ph_we)  phase_o   <= upd.ph;
                if (upd.sq_we)  seq_o     <= upd.sq;
                if (upd.cdb_we) cdb_off_o <= upd.cdb;
                if (upd.dma_we) dma_cmd_o <= op_dma;
            end
        end
    end

    // One-cycle requests to neighbouring logic
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fifo_flush_o     <= 1'b0;
            fifo_flags_clr_o <= 1'b0;
            cmd_launch_o     <= 1'b0;
        end else begin
            fifo_flush_o     <= apply && upd.flush;
            fifo_flags_clr_o <= apply && upd.fclr;
            cmd_launch_o     <= apply && upd.launch;
        end
    end
endmodule

// File: rtl/sel_cmd_sequencer_chk.sv
// Property checker for the selection command sequencer, bound to the top.
module sel_cmd_sequencer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] phase_o,
    input logic [7:0] intr_o,
    input logic [2:0] seq_o,
    input logic       irq_o,
    input logic       illegal_o,
    input logic       fifo_flush_o,
    input logic       cmd_launch_o
);
    // R4
    launch_cmd_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_launch_o |-> (phase_o == 3'd2) && (seq_o == 3'd4) && irq_o);

    // R14
    irq_cause_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == (intr_o != 8'h00));

    // R10
    flush_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_flush_o |=> !fifo_flush_o);

    // R12
    illegal_no_reg_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(illegal_o) |-> $stable(phase_o) && $stable(seq_o));

    // R13
    launch_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_launch_o |=> !cmd_launch_o);

    // R7
    seq_step_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_o == 3'd0) || (seq_o == 3'd1) || (seq_o == 3'd4));
endmodule

bind sel_cmd_sequencer sel_cmd_sequencer_chk i_chk (
    .clk(clk), .rst_n(rst_n), .phase_o(phase_o), .intr_o(intr_o),
    .seq_o(seq_o), .irq_o(irq_o), .illegal_o(illegal_o),
    .fifo_flush_o(fifo_flush_o), .cmd_launch_o(cmd_launch_o)
);

// File: tb/test_sel_cmd_sequencer.sv
module test_sel_cmd_sequencer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_wr = 1'b0;
    logic [7:0] cmd_byte = 8'h00;
    logic [2:0] dest_id = 3'd0;
    logic [7:0] tgt_present = 8'hDF;
    logic [4:0] cmdq_count = 5'd0;
    logic       rst_report_dis = 1'b0;
    logic       intr_ack = 1'b0;
    logic [2:0] phase_o, seq_o;
    logic [7:0] intr_o;
    logic       irq_o, cdb_off_o, dma_cmd_o, illegal_o;
    logic       fifo_flush_o, fifo_flags_clr_o, cmd_launch_o, busy_o;

    always #4 clk = ~clk;

    sel_cmd_sequencer i_sel_cmd_sequencer (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_byte(cmd_byte),
        .dest_id(dest_id), .tgt_present(tgt_present), .cmdq_count(cmdq_count),
        .rst_report_dis(rst_report_dis), .intr_ack(intr_ack),
        .phase_o(phase_o), .intr_o(intr_o), .seq_o(seq_o), .irq_o(irq_o),
        .cdb_off_o(cdb_off_o), .dma_cmd_o(dma_cmd_o), .illegal_o(illegal_o),
        .fifo_flush_o(fifo_flush_o), .fifo_flags_clr_o(fifo_flags_clr_o),
        .cmd_launch_o(cmd_launch_o), .busy_o(busy_o)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_vec = 0;
    int n_bad = 0;
    int last_due = -100;

    // Expected outputs: {phase, cause, step, irq, cdb, dma, illegal, flush, fclr, launch}
    logic [20:0] exq[$];
    int          dueq[$];
    string       tagq[$];

    // Reference model registers
    logic [2:0] m_ph = 0, m_sq = 0;
    logic [7:0] m_ir = 0;
    logic       m_irq = 0, m_cdb = 0, m_dma = 0, m_ill = 0;

    function automatic logic [20:0] snap(input logic fl, input logic fc, input logic la);
        return {m_ph, m_ir, m_sq, m_irq, m_cdb, m_dma, m_ill, fl, fc, la};
    endfunction

    task automatic compare(input logic [20:0] exp_v, input string tag);
        logic [20:0] got;
        got = {phase_o, intr_o, seq_o, irq_o, cdb_off_o, dma_cmd_o, illegal_o,
               fifo_flush_o, fifo_flags_clr_o, cmd_launch_o};
        n_vec++;
        if (got !== exp_v) begin
            n_bad++;
            $display("FAIL %s at cycle %0d: actual %06h expected %06h", tag, cyc, got, exp_v);
        end
    endtask

    // Scoreboard monitor: compare the head item in its due cycle
    always @(negedge clk) begin
        if (dueq.size() != 0 && dueq[0] == cyc) begin
            logic [20:0] e;
            string       t;
            int          d;
            e = exq.pop_front();
            t = tagq.pop_front();
            d = dueq.pop_front();
            compare(e, t);
        end
    end

    task automatic push_exp(input logic [20:0] v, input int due, input string tag);
        exq.push_back(v);
        dueq.push_back(due);
        tagq.push_back(tag);
    endtask

    // Driver: write one command (called on a falling edge) and predict its result
    task automatic issue(input logic [7:0] b, input string tag);
        logic fl, fc, la, hit, bytes;
        int   due;
        fl = 0; fc = 0; la = 0;
        hit   = tgt_present[dest_id];
        bytes = (cmdq_count != 0);
        case (b[6:0])
            7'h00: m_dma = b[7];
            7'h01: begin m_dma = b[7]; fl = 1; end
            7'h03: begin
                m_dma = b[7];
                if (!rst_report_dis) begin m_ir = m_ir | 8'h80; m_irq = 1; end
            end
            7'h11: begin m_dma = b[7]; m_ir = m_ir | 8'h08; m_ph = 3'd7; m_irq = 1; end
            7'h12: begin m_dma = b[7]; m_ir = m_ir | 8'h20; m_sq = 3'd0; m_irq = 1; fc = 1; end
            7'h41, 7'h42, 7'h43: begin
                m_dma = b[7];
                if (!hit) begin
                    m_ph = 3'd0; m_ir = 8'h20; m_sq = 3'd0; m_irq = 1;
                end else begin
                    m_ph = (b[6:0] == 7'h43) ? 3'd6 : 3'd2;
                    m_sq = (b[6:0] == 7'h43) ? 3'd1 : 3'd4;
                    if (bytes) begin
                        m_ir  = m_ir | 8'h18;
                        m_irq = 1;
                        m_cdb = (b[6:0] != 7'h41);
                        la    = (b[6:0] != 7'h43);
                    end
                end
            end
            default: m_ill = 1;
        endcase
        due = cyc + 3;
        if (last_due + 2 > due) due = last_due + 2;
        last_due = due;
        push_exp(snap(fl, fc, la), due, tag);
        cmd_byte = b;
        cmd_wr   = 1'b1;
        @(negedge clk);
        cmd_wr   = 1'b0;
    endtask

    task automatic ack(input string tag);
        m_ir = 0; m_irq = 0; m_ill = 0;
        push_exp(snap(0, 0, 0), cyc + 1, tag);
        intr_ack = 1'b1;
        @(negedge clk);
        intr_ack = 1'b0;
    endtask

    task automatic drain();
        while (dueq.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        compare(snap(0, 0, 0), "R1 reset");
        n_vec++;
        if (busy_o !== 1'b0) begin
            n_bad++;
            $display("FAIL R1 busy: actual %0b expected 0", busy_o);
        end
        @(negedge clk);

        // R4: select, target 3 present, bytes waiting
        dest_id = 3'd3; cmdq_count = 5'd6;
        issue(8'h41, "R4 select launch"); drain();
        ack("R14 ack clears cause"); drain();
        // R5 and R2: select with attention, DMA bit set
        issue(8'hC2, "R5 select-atn cdb offset, R2 dma flag"); drain();
        // R6: stop variant, cause accumulates
        issue(8'h43, "R6 select-atn-stop message out"); drain();
        // R3: absent target replaces cause
        dest_id = 3'd5;
        issue(8'h42, "R3 missing target disconnect"); drain();
        ack("R14 ack after disconnect"); drain();
        // R7: present target, no bytes
        dest_id = 3'd2; cmdq_count = 5'd0;
        issue(8'h41, "R7 select no bytes"); drain();
        issue(8'h43, "R7 stop variant no bytes"); drain();
        // R8 and R9
        issue(8'h11, "R8 initiator complete"); drain();
        issue(8'h12, "R9 message accept"); drain();
        ack("R14 ack"); drain();
        // R10: flush and no-op
        issue(8'h01, "R10 flush pulse"); drain();
        issue(8'h00, "R10 no-op"); drain();
        // R11: bus reset with and without report
        rst_report_dis = 1'b1;
        issue(8'h03, "R11 bus reset suppressed"); drain();
        rst_report_dis = 1'b0;
        issue(8'h03, "R11 bus reset reported"); drain();
        ack("R14 ack"); drain();
        // R12: unrecognised opcode
        issue(8'h7F, "R12 illegal opcode"); drain();
        ack("R14 ack clears illegal"); drain();
        // R13: three commands back to back, held and run in order
        dest_id = 3'd3; cmdq_count = 5'd2;
        issue(8'h11, "R13 first of burst");
        issue(8'h81, "R13 second of burst held");
        issue(8'h41, "R13 third of burst held");
        drain();
        summary();
        $finish;
    end
endmodule